// File: doc/BRIEF.md
# Aligning Carry-Save Mantissa Multiplier

This block multiplies two unsigned 16-bit mantissas one multiplier bit per clock. The running partial product is kept in redundant form, a carry word and a sum word, and no carry is ever propagated inside the block. Its intended use is as one lane of a sum-of-products engine, where many such lanes feed a common carry-save accumulator.

Each lane carries a small pending-alignment counter. Whenever that counter is nonzero during a multiply cycle, the partial product is moved one extra place right and the multiplicand register also moves one place right, so later partial products keep their correct weight. The counter is loaded from a shift count at start. It can be raised by one-cycle increment requests while the multiply runs, for example when a shared reference exponent grows. Any alignment still pending after the sixteenth multiplier bit is worked off in extra cycles before completion is signalled. If the total requested alignment reaches sixteen places, the contribution cannot matter at 16-bit precision and the lane produces zero.

The internal registers are wide enough that no product bit is discarded. The visible result is the top 16 bits of each word, which together equal the aligned product truncated to 16 bits, or one less, because of the carry still held in the lower bits.

Top module: `csam_top`

## Requirements
- R1: After reset, carry_o and sum_o are zero and done_o is low.
- R2: With no alignment, let P = A*B. Once done_o is high, carry_o + sum_o (a 17-bit sum) equals floor(P / 2^16) or that value minus one.
- R3: With no alignment left at the end, done_o is high for exactly one cycle. It is seen after the 16th rising edge following the edge that accepts start_i.
- R4: A start shift count s in 0..15 makes carry_o + sum_o equal floor(P / 2^(16+s)) or one less. Latency stays 16 edges.
- R5: Each shift_inc_i pulse sampled while an operation runs adds one place of alignment. If a pulse coincides with an alignment step, both take effect.
- R6: Alignment pending when the 16 multiply cycles end is applied one place per extra cycle. done_o then follows, so latency is 16 plus the number of drain cycles.
- R7: If the start count is 16 or more, or the start count plus the accepted increments reaches 16, both carry_o and sum_o are zero when done_o is high.
- R8: start_i is ignored while an operation is in progress. The result and latency are those of the accepted operation, and no second done_o follows.
- R9: While idle, shift_inc_i is ignored and the outputs hold their last values. An increment given while idle does not alter the next operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts an operation when idle |
| mcand_i | input | 16 | Multiplicand mantissa, sampled with start_i |
| mplier_i | input | 16 | Multiplier mantissa, sampled with start_i |
| shamt_i | input | 5 | Initial alignment count, sampled with start_i; 16 or more forces zero |
| shift_inc_i | input | 1 | Adds one place of alignment during an operation |
| carry_o | output | 16 | Upper 16 bits of the carry word |
| sum_o | output | 16 | Upper 16 bits of the sum word |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
An increment request can arrive on the same edge where the counter performs an alignment step and decrements. When that happens the counter must keep its value, not lose either event. The bench provokes this by loading a count of three and pulsing the increment on the first two multiply edges. It expects an effective alignment of five with unchanged latency. A second collision is an increment on the final multiply edge while a step is still pending, which must push the lane into a drain cycle. Both cases are judged from the output words against the truncated shifted product and from the edge count to done_o.

// File: rtl/csam_pkg.sv
`timescale 1ns/1ps
package csam_pkg;
    localparam int MANT_W    = 16;
    localparam int ALIGN_W   = 4;
    localparam int MAX_ALIGN = (1 << ALIGN_W) - 1;
    localparam int MC_W      = MANT_W + MAX_ALIGN;
    localparam int ACC_W     = 2 * MANT_W + MAX_ALIGN;
    localparam int ITER_W    = $clog2(MANT_W);
    localparam int PP_PAD    = ACC_W - MC_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MUL   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } csam_state_e;

    typedef struct packed {
        logic [ACC_W-1:0] carry;
        logic [ACC_W-1:0] sum;
    } cs_word_t;

    // One carry-save iteration: add pp, then move right by one (or two
    // places when an alignment step is taken). The carry vector is held
    // already shifted, so its natural left shift cancels one place.
    function automatic cs_word_t cs_iter(input cs_word_t a,
                                         input logic [ACC_W-1:0] pp,
                                         input logic extra);
        cs_word_t         r;
        logic [ACC_W-1:0] x;
        logic [ACC_W-1:0] m;
        x = a.sum ^ a.carry ^ pp;
        m = (a.sum & a.carry) | (a.sum & pp) | (a.carry & pp);
        if (extra) begin
            r.sum   = x >> 2;
            r.carry = m >> 1;
        end else begin
            r.sum   = x >> 1;
            r.carry = m;
        end
        return r;
    endfunction

    function automatic cs_word_t cs_halve(input cs_word_t a);
        cs_word_t r;
        r.sum   = a.sum >> 1;
        r.carry = a.carry >> 1;
        return r;
    endfunction
endpackage

// File: rtl/csam_align.sv
`timescale 1ns/1ps
module csam_align
    import csam_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [ALIGN_W:0]   shamt,
    input  logic               active,
    input  logic               inc,
    output logic               step,
    output logic               kill,
    output logic               kill_set,
    output logic               pend_clear
);
    logic [ALIGN_W-1:0] cnt_q;
    logic [ALIGN_W:0]   tot_q;
    logic               kill_q;
    logic [ALIGN_W-1:0] cnt_n;

    always_comb begin
        step     = active && !kill_q && (cnt_q != '0);
        kill_set = active && !kill_q && inc && (tot_q == ALIGN_W'(MAX_ALIGN));
        cnt_n    = cnt_q - ALIGN_W'(step) + ALIGN_W'(inc && active && !kill_q);
        pend_clear = kill_q || kill_set || (cnt_n == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            tot_q  <= '0;
            kill_q <= 1'b0;
        end else if (load) begin
            cnt_q  <= shamt[ALIGN_W] ? '0 : shamt[ALIGN_W-1:0];
            tot_q  <= shamt;
            kill_q <= shamt[ALIGN_W];
        end else if (active && !kill_q) begin
            if (kill_set) begin
                kill_q <= 1'b1;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_n;
                tot_q <= tot_q + (ALIGN_W+1)'(inc);
            end
        end
    end

    assign kill = kill_q;

    // R5
    step_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !inc && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R5
    step_inc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (step && inc && !kill_set && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/csam_seq.sv
`timescale 1ns/1ps
module csam_seq
    import csam_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic pend_clear,
    output logic load,
    output logic mul_en,
    output logic drain_en,
    output logic done
);
    csam_state_e        st_q;
    logic [ITER_W-1:0]  it_q;
    logic               last_it;

    assign last_it  = (it_q == ITER_W'(MANT_W - 1));
    assign load     = (st_q == ST_IDLE) && start;
    assign mul_en   = (st_q == ST_MUL);
    assign drain_en = (st_q == ST_DRAIN);
    assign done     = (st_q == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
            it_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (start) begin
                    st_q <= ST_MUL;
                    it_q <= '0;
                end
                ST_MUL: begin
                    it_q <= it_q + 1'b1;
                    if (last_it) st_q <= pend_clear ? ST_DONE : ST_DRAIN;
                end
                ST_DRAIN: if (pend_clear) st_q <= ST_DONE;
                ST_DONE:  st_q <= ST_IDLE;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (mul_en && !last_it && start) |=> (mul_en && it_q == $past(it_q) + 1'b1));
endmodule

// File: rtl/csam_datapath.sv
`timescale 1ns/1ps
module csam_datapath
    import csam_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              zero_load,
    input  logic [MANT_W-1:0] mcand,
    input  logic [MANT_W-1:0] mplier,
    input  logic              mul_en,
    input  logic              drain_en,
    input  logic              step,
    input  logic              kill,
    input  logic              kill_set,
    output logic [MANT_W-1:0] carry_hi,
    output logic [MANT_W-1:0] sum_hi
);
    cs_word_t           acc_q;
    logic [MC_W-1:0]    mc_q;
    logic [MANT_W-1:0]  mp_q;
    logic [ACC_W-1:0]   pp;

    assign pp = (mp_q[0] && !kill) ? {mc_q, {PP_PAD{1'b0}}} : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            mc_q  <= '0;
            mp_q  <= '0;
        end else if (load) begin
            acc_q <= '0;
            mc_q  <= zero_load ? '0 : {mcand, {MAX_ALIGN{1'b0}}};
            mp_q  <= mplier;
        end else if (kill_set) begin
            acc_q <= '0;
            mc_q  <= '0;
            mp_q  <= mp_q >> 1;
        end else if (mul_en) begin
            acc_q <= cs_iter(acc_q, pp, step);
            mp_q  <= mp_q >> 1;
            if (step) mc_q <= mc_q >> 1;
        end else if (drain_en && step) begin
            acc_q <= cs_halve(acc_q);
        end
    end

    assign carry_hi = acc_q.carry[ACC_W-1 -: MANT_W];
    assign sum_hi   = acc_q.sum[ACC_W-1 -: MANT_W];

    // R7
    kill_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (kill && !load) |-> (acc_q == '0 && mc_q == '0));
endmodule

// File: rtl/csam_top.sv
`timescale 1ns/1ps
module csam_top
    import csam_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [15:0]       mcand_i,
    input  logic [15:0]       mplier_i,
    input  logic [4:0]        shamt_i,
    input  logic              shift_inc_i,
    output logic [15:0]       carry_o,
    output logic [15:0]       sum_o,
    output logic              done_o
);
    logic load, mul_en, drain_en, step, kill, kill_set, pend_clear;

    csam_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start_i),
        .pend_clear (pend_clear),
        .load       (load),
        .mul_en     (mul_en),
        .drain_en   (drain_en),
        .done       (done_o)
    );

    csam_align u_align (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .shamt      (shamt_i),
        .active     (mul_en || drain_en),
        .inc        (shift_inc_i),
        .step       (step),
        .kill       (kill),
        .kill_set   (kill_set),
        .pend_clear (pend_clear)
    );

    csam_datapath u_dp (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .zero_load (shamt_i[ALIGN_W]),
        .mcand     (mcand_i),
        .mplier    (mplier_i),
        .mul_en    (mul_en),
        .drain_en  (drain_en),
        .step      (step),
        .kill      (kill),
        .kill_set  (kill_set),
        .carry_hi  (carry_o),
        .sum_hi    (sum_o)
    );

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mul_en && !drain_en && !start_i) |=> ($stable(carry_o) && $stable(sum_o)));
endmodule

// File: tb/csam_top_test.sv
`timescale 1ns/1ps
module csam_top_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [15:0] mcand, mplier;
    logic [4:0]  shamt;
    logic        inc;
    logic [15:0] carry, sum;
    logic        done;
    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;

    csam_top uut (
        .clk(clk), .rst(rst), .start_i(start), .mcand_i(mcand),
        .mplier_i(mplier), .shamt_i(shamt), .shift_inc_i(inc),
        .carry_o(carry), .sum_o(sum), .done_o(done)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Result within one of the truncated aligned product, or zero if killed.
    task automatic check_val(input [15:0] a, input [15:0] b, input int k, input int hs, input string req);
        longint e;
        if (k >= 16) begin
            check(carry == 16'd0 && sum == 16'd0, req, hs, 0);
        end else begin
            e = (longint'(a) * longint'(b)) >> (16 + k);
            check(hs == e || hs + 1 == e, req, hs, e);
        end
    endtask

    // Runs one operation. incm bit e drives shift_inc_i before edge e
    // (edge 0 accepts start). rstart > 0 pulses start again at that edge.
    task automatic do_op(input [15:0] a, input [15:0] b, input [4:0] s,
                         input logic [39:0] incm, input int rstart,
                         output int lat, output int hs);
        @(negedge clk);
        start = 1'b1; mcand = a; mplier = b; shamt = s; inc = 1'b0;
        @(posedge clk); #1;
        lat = 0; hs = 0;
        for (int e = 1; e < 40 && lat == 0; e++) begin
            @(negedge clk);
            start = (e == rstart);
            if (e == rstart) begin mcand = ~a; mplier = ~b; shamt = 5'd0; end
            inc = incm[e];
            @(posedge clk); #1;
            if (done) begin
                lat = e;
                hs = int'(carry) + int'(sum);
            end
        end
        @(negedge clk);
        start = 1'b0; inc = 1'b0;
        @(posedge clk); #1;
        check(!done, "R3 done width", done, 0);
    endtask

    task automatic t_reset;
        check(carry == 0 && sum == 0, "R1 outputs", int'(carry) + int'(sum), 0);
        check(!done, "R1 done", done, 0);
    endtask

    task automatic t_plain;
        logic [15:0] av [5] = '{16'hFFFF, 16'h8000, 16'h1234, 16'h0001, 16'h0000};
        logic [15:0] bv [5] = '{16'hFFFF, 16'h8000, 16'hABCD, 16'h0001, 16'h7777};
        int lat, hs;
        for (int i = 0; i < 5; i++) begin
            do_op(av[i], bv[i], 5'd0, 40'd0, 0, lat, hs);
            check_val(av[i], bv[i], 0, hs, "R2 product");
            check(lat == 16, "R3 latency", lat, 16);
        end
    endtask

    task automatic t_align;
        int sv [3] = '{1, 7, 15};
        int lat, hs;
        for (int i = 0; i < 3; i++) begin
            do_op(16'hFFFF, 16'hF00F, 5'(sv[i]), 40'd0, 0, lat, hs);
            check_val(16'hFFFF, 16'hF00F, sv[i], hs, "R4 start shift");
            check(lat == 16, "R4 latency", lat, 16);
        end
    endtask

    task automatic t_inc_mid;
        int lat, hs;
        do_op(16'hFEDC, 16'hBA98, 5'd0, 40'h18, 0, lat, hs);   // edges 3,4
        check_val(16'hFEDC, 16'hBA98, 2, hs, "R5 mid increments");
        check(lat == 16, "R5 latency", lat, 16);
        do_op(16'hFFFF, 16'hFFFF, 5'd3, 40'h6, 0, lat, hs);    // edges 1,2 collide with steps
        check_val(16'hFFFF, 16'hFFFF, 5, hs, "R5 inc with step");
        check(lat == 16, "R5 collision latency", lat, 16);
    endtask

    task automatic t_drain;
        int lat, hs;
        do_op(16'hFFFF, 16'hC3C3, 5'd0, 40'h10000, 0, lat, hs);  // edge 16
        check_val(16'hFFFF, 16'hC3C3, 1, hs, "R6 drain one");
        check(lat == 17, "R6 latency one", lat, 17);
        do_op(16'hFFFF, 16'hC3C3, 5'd0, 40'h18000, 0, lat, hs);  // edges 15,16
        check_val(16'hFFFF, 16'hC3C3, 2, hs, "R6 drain with step");
        check(lat == 17, "R6 latency step", lat, 17);
    endtask

    task automatic t_kill;
        int lat, hs;
        do_op(16'hFFFF, 16'hFFFF, 5'd16, 40'd0, 0, lat, hs);
        check_val(16'hFFFF, 16'hFFFF, 16, hs, "R7 start 16");
        do_op(16'hFFFF, 16'hFFFF, 5'd20, 40'd0, 0, lat, hs);
        check_val(16'hFFFF, 16'hFFFF, 20, hs, "R7 start 20");
        do_op(16'hFFFF, 16'hFFFF, 5'd15, 40'h20, 0, lat, hs);   // edge 5
        check_val(16'hFFFF, 16'hFFFF, 16, hs, "R7 inc reaches 16");
        check(lat == 16, "R7 latency", lat, 16);
        do_op(16'hFFFF, 16'hFFFF, 5'd14, 40'h60, 0, lat, hs);   // edges 5,6
        check_val(16'hFFFF, 16'hFFFF, 16, hs, "R7 two incs");
    endtask

    task automatic t_busy;
        int lat, hs, extra;
        do_op(16'h9ABC, 16'hDEF0, 5'd0, 40'd0, 5, lat, hs);
        check_val(16'h9ABC, 16'hDEF0, 0, hs, "R8 busy start");
        check(lat == 16, "R8 latency", lat, 16);
        extra = 0;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); #1;
            if (done) extra++;
        end
        check(extra == 0, "R8 no second done", extra, 0);
    endtask

    task automatic t_idle;
        int lat, hs, c0, s0, moved;
        do_op(16'hAAAA, 16'h5555, 5'd0, 40'd0, 0, lat, hs);
        c0 = int'(carry); s0 = int'(sum); moved = 0;
        @(negedge clk); inc = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1;
            if (int'(carry) != c0 || int'(sum) != s0 || done) moved++;
        end
        @(negedge clk); inc = 1'b0;
        check(moved == 0, "R9 idle hold", moved, 0);
        do_op(16'hFFFF, 16'hFFFF, 5'd0, 40'd0, 0, lat, hs);
        check_val(16'hFFFF, 16'hFFFF, 0, hs, "R9 idle inc ignored");
        check(lat == 16, "R9 latency", lat, 16);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; inc = 1'b0;
        mcand = '0; mplier = '0; shamt = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        t_reset();
        t_plain();
        t_align();
        t_inc_mid();
        t_drain();
        t_kill();
        t_busy();
        t_idle();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule